// File: doc/BRIEF.md
# MII Receive Frame Parser

This block sits behind an MII receive interface and turns the 4-bit receive stream into a byte stream for a downstream buffer or DMA engine. It watches the data-valid and receive-error strobes and looks for a run of preamble nibbles closed by a start frame delimiter. It then joins nibbles into bytes and keeps the first six bytes until the destination address can be judged. The address filter accepts the station's own address, broadcast, multicast, or anything at all when promiscuous mode is on. Frames that fail the filter are dropped without a trace on the output.

Accepted frames are forwarded one byte per strobe, from the first destination address byte through the last payload byte. The four trailing check bytes are consumed and not forwarded. A separate end strobe closes each frame and carries one error flag. That flag covers a bad CRC-32, a receive-error strobe seen inside the frame, a frame below the minimum length, or an odd nibble count. Errored frames are still forwarded in full, so the buffer can keep or discard them. Carrier activity that does not open with a valid preamble and delimiter raises a one-cycle illegal-carrier pulse. A receive-enable input holds the whole parser in a halted state while it is low.

Top module: `mii_rx_parser`

## Requirements
- R1: After reset, and for as long as `rx_en` is low, the parser stays halted. `out_valid`, `out_eof` and `illegal_carrier` stay low whatever the MII inputs do. All outputs are 0 after reset.
- R2: Nibbles are assembled low nibble first. A frame starts only when the nibble 0xD arrives after at least `PRE_MIN` (default 4) consecutive 0x5 nibbles, with data-valid held high from the first 0x5.
- R3: A carrier that does any of the following raises `illegal_carrier` for exactly one cycle and produces no frame output: it opens with a nibble other than 0x5, shows 0xD before `PRE_MIN` 0x5 nibbles, shows any other nibble before the delimiter, asserts `mii_rxer` before the delimiter, or drops data-valid before the delimiter.
- R4: A frame is accepted when any of these holds: the destination address equals `own_addr`, where `own_addr[7:0]` is the first byte on the wire; all six address bytes are 0xFF; bit 0 of the first address byte is 1; or `promisc` is high. Any other frame produces no output at all.
- R5: An accepted frame of N bytes, counted after the delimiter and including the 4 check bytes, yields exactly N-4 strobes of `out_valid`. They carry the received bytes in order, and `out_sof` is set on the first strobe only.
- R6: Each accepted frame is closed by one `out_eof` pulse, after its last data strobe and in a cycle where `out_valid` is low. `out_err` is only ever high together with `out_eof`.
- R7: The CRC-32 uses the reflected polynomial 0x04C11DB7 with an all-ones start value and covers the destination address through the 4 check bytes. The frame is good when the check bytes equal the inverted CRC of the bytes before them, sent least significant byte first. This is the same as the running register reaching 0xDEBB20E3, the bit-reversed form of 0xC704DD7B. A mismatch sets `out_err` at `out_eof`.
- R8: If `mii_rxer` is high on any nibble after the delimiter, the frame is still forwarded in full and `out_err` is set at `out_eof`.
- R9: A frame with fewer than `MIN_FRAME` bytes (default 64, check bytes included) sets `out_err` at `out_eof`.
- R10: A frame that ends on an odd number of nibbles after the delimiter sets `out_err` at `out_eof`. The unpaired nibble is not forwarded.
- R11: A frame whose data-valid drops before six address bytes are complete produces no data, no `out_eof` and no `illegal_carrier`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, one nibble per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receive enable; low holds the parser halted |
| promisc | input | 1 | Accept frames regardless of destination |
| own_addr | input | 48 | Station address, first wire byte in bits 7:0 |
| mii_rxd | input | 4 | MII receive nibble |
| mii_rxdv | input | 1 | MII receive data valid |
| mii_rxer | input | 1 | MII receive error |
| out_valid | output | 1 | Byte strobe for `out_data` |
| out_data | output | 8 | Forwarded frame byte |
| out_sof | output | 1 | First byte of a frame, with `out_valid` |
| out_eof | output | 1 | End-of-frame pulse, with `out_valid` low |
| out_err | output | 1 | Frame error flag, valid with `out_eof` |
| illegal_carrier | output | 1 | One-cycle pulse on an invalid carrier start |

## Verification
The properties take it for granted that `rx_en`, `promisc` and `own_addr` change only between frames. They also assume the gap between two carriers is at least a few cycles, so the drain of the previous frame ends before a new preamble arrives. The stimulus keeps to both: it sets the mode inputs before each frame and leaves ten idle cycles after every carrier. Random frames vary length, address class, promiscuous mode, CRC corruption, error strobes and an extra trailing nibble. Directed carriers cover the malformed starts and the address-truncated frame.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;

  localparam int ADDR_BYTES = 6;
  localparam logic [3:0] PRE_NIB = 4'h5;
  localparam logic [3:0] SFD_NIB = 4'hD;
  localparam logic [31:0] CRC_POLY_R = 32'hEDB88320;
  localparam logic [31:0] CRC_GOOD_R = 32'hDEBB20E3;

  typedef enum logic [3:0] {
    S_HALT, S_IDLE, S_PRE, S_SFDW, S_DEST, S_DATA,
    S_ERRN, S_DRAIN, S_ENDR, S_DISC, S_ILLC
  } rx_state_e;

  // one byte through the reflected CRC-32 register, bit 0 first
  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int b = 0; b < 8; b++) begin
      if (r[0] ^ d[b]) r = (r >> 1) ^ CRC_POLY_R;
      else             r = r >> 1;
    end
    return r;
  endfunction

  function automatic logic addr_is_bcast(input logic [8*ADDR_BYTES-1:0] da);
    return &da;
  endfunction

  function automatic logic addr_is_mcast(input logic [8*ADDR_BYTES-1:0] da);
    return da[0];
  endfunction

endpackage

// File: rtl/mii_nibble_asm.sv
module mii_nibble_asm (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       nib_en,
  input  logic [3:0] nib,
  output logic       byte_stb,
  output logic [7:0] byte_data,
  output logic       half
);
  logic       half_q;
  logic [3:0] lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      lo_q   <= 4'h0;
    end else if (clr) begin
      half_q <= 1'b0;
    end else if (nib_en) begin
      if (!half_q) lo_q <= nib;
      half_q <= ~half_q;
    end
  end

  assign byte_stb  = nib_en && half_q && !clr;
  assign byte_data = {nib, lo_q};
  assign half      = half_q;
endmodule

// File: rtl/mii_rx_crc.sv
module mii_rx_crc
  import mii_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init,
  input  logic       byte_stb,
  input  logic [7:0] byte_data,
  output logic       crc_ok
);
  logic [31:0] crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        crc_q <= '1;
    else if (init)     crc_q <= '1;
    else if (byte_stb) crc_q <= crc32_step(crc_q, byte_data);
  end

  assign crc_ok = (crc_q == CRC_GOOD_R);
endmodule

// File: rtl/mii_rx_hold.sv
module mii_rx_hold #(
  parameter int DEPTH = 6,
  parameter int W     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               push,
  input  logic               drain,
  input  logic [W-1:0]       din,
  output logic [W-1:0]       dout,
  output logic [DEPTH*W-1:0] flat,
  output logic               full
);
  localparam int FW = $clog2(DEPTH + 1);

  logic [W-1:0] slot_q [DEPTH];
  logic [FW-1:0] fill_q;
  logic shift;

  assign shift = push || drain;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n)     slot_q[i] <= '0;
        else if (shift) slot_q[i] <= push ? din : '0;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n)     slot_q[i] <= '0;
        else if (shift) slot_q[i] <= slot_q[i-1];
      end
    end
    // oldest byte lands in the lowest lane
    assign flat[i*W +: W] = slot_q[DEPTH-1-i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                              fill_q <= '0;
    else if (clr)                            fill_q <= '0;
    else if (push && fill_q != FW'(DEPTH))   fill_q <= fill_q + 1'b1;
  end

  assign full = (fill_q == FW'(DEPTH));
  assign dout = slot_q[DEPTH-1];
endmodule

// File: rtl/mii_addr_filter.sv
module mii_addr_filter
  import mii_rx_pkg::*;
(
  input  logic [8*ADDR_BYTES-1:0] da,
  input  logic [8*ADDR_BYTES-1:0] own,
  input  logic                    promisc,
  output logic                    accept
);
  logic hit_own, hit_bc, hit_mc;

  assign hit_own = (da == own);
  assign hit_bc  = addr_is_bcast(da);
  assign hit_mc  = addr_is_mcast(da);
  assign accept  = promisc || hit_own || hit_bc || hit_mc;
endmodule

// File: rtl/mii_rx_parser.sv
module mii_rx_parser
  import mii_rx_pkg::*;
#(
  parameter int PRE_MIN   = 4,
  parameter int MIN_FRAME = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_en,
  input  logic        promisc,
  input  logic [47:0] own_addr,
  input  logic [3:0]  mii_rxd,
  input  logic        mii_rxdv,
  input  logic        mii_rxer,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic        out_sof,
  output logic        out_eof,
  output logic        out_err,
  output logic        illegal_carrier
);
  localparam int PW    = $clog2(PRE_MIN + 1);
  localparam int CW    = $clog2(MIN_FRAME + 1);
  localparam int AW    = 8 * ADDR_BYTES;

  rx_state_e state_q, state_d;
  logic [PW-1:0] pre_cnt_q;
  logic [CW-1:0] byte_cnt_q;
  logic          err_rx_q, dribble_q, first_pend_q, drain_cnt_q;

  // named internal events
  logic in_frame, nib_en, byte_stb, half, sfd_hit, illegal_ev;
  logic emit, accept, hold_full, crc_ok, runt, frame_end;
  logic [7:0] byte_data, hold_out;
  logic [AW-1:0] da_flat;

  assign in_frame = (state_q == S_DEST) || (state_q == S_DATA) || (state_q == S_ERRN);
  assign nib_en   = mii_rxdv && in_frame;
  assign frame_end = ((state_q == S_DATA) || (state_q == S_ERRN)) && !mii_rxdv;

  mii_nibble_asm u_asm (
    .clk(clk), .rst_n(rst_n), .clr(!in_frame), .nib_en(nib_en), .nib(mii_rxd),
    .byte_stb(byte_stb), .byte_data(byte_data), .half(half)
  );

  mii_rx_crc u_crc (
    .clk(clk), .rst_n(rst_n), .init(sfd_hit), .byte_stb(byte_stb),
    .byte_data(byte_data), .crc_ok(crc_ok)
  );

  mii_rx_hold #(.DEPTH(ADDR_BYTES), .W(8)) u_hold (
    .clk(clk), .rst_n(rst_n), .clr(sfd_hit), .push(byte_stb),
    .drain(state_q == S_DRAIN), .din(byte_data), .dout(hold_out),
    .flat(da_flat), .full(hold_full)
  );

  mii_addr_filter u_filt (
    .da(da_flat), .own(own_addr), .promisc(promisc), .accept(accept)
  );

  assign emit = (byte_stb && hold_full && ((state_q == S_DATA) || (state_q == S_ERRN)))
             || (state_q == S_DRAIN);
  assign runt = (byte_cnt_q != CW'(MIN_FRAME));

  // next-state logic
  always_comb begin
    state_d    = state_q;
    sfd_hit    = 1'b0;
    illegal_ev = 1'b0;
    case (state_q)
      S_HALT: if (rx_en) state_d = S_IDLE;
      S_IDLE: begin
        if (mii_rxdv) begin
          if (!mii_rxer && mii_rxd == PRE_NIB) state_d = S_PRE;
          else begin illegal_ev = 1'b1; state_d = S_ILLC; end
        end
      end
      S_PRE: begin
        if (!mii_rxdv || mii_rxer || mii_rxd != PRE_NIB) begin
          illegal_ev = 1'b1; state_d = S_ILLC;
        end else if (pre_cnt_q == PW'(PRE_MIN - 1)) begin
          state_d = S_SFDW;
        end
      end
      S_SFDW: begin
        if (!mii_rxdv || mii_rxer) begin
          illegal_ev = 1'b1; state_d = S_ILLC;
        end else if (mii_rxd == SFD_NIB) begin
          sfd_hit = 1'b1; state_d = S_DEST;
        end else if (mii_rxd != PRE_NIB) begin
          illegal_ev = 1'b1; state_d = S_ILLC;
        end
      end
      S_DEST: begin
        if (hold_full)      state_d = !accept ? S_DISC : (err_rx_q ? S_ERRN : S_DATA);
        else if (!mii_rxdv) state_d = S_IDLE;
      end
      S_DATA: begin
        if (!mii_rxdv)    state_d = S_DRAIN;
        else if (mii_rxer) state_d = S_ERRN;
      end
      S_ERRN:  if (!mii_rxdv) state_d = S_DRAIN;
      S_DRAIN: if (drain_cnt_q) state_d = S_ENDR;
      S_ENDR:  state_d = S_IDLE;
      S_DISC:  if (!mii_rxdv) state_d = S_IDLE;
      S_ILLC:  if (!mii_rxdv) state_d = S_IDLE;
      default: state_d = S_HALT;
    endcase
    if (!rx_en) state_d = S_HALT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= S_HALT;
      pre_cnt_q    <= '0;
      byte_cnt_q   <= '0;
      err_rx_q     <= 1'b0;
      dribble_q    <= 1'b0;
      first_pend_q <= 1'b0;
      drain_cnt_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE)                  pre_cnt_q <= PW'(1);
      else if (state_q == S_PRE && mii_rxdv)  pre_cnt_q <= pre_cnt_q + 1'b1;

      if (sfd_hit)                                  byte_cnt_q <= '0;
      else if (byte_stb && byte_cnt_q != CW'(MIN_FRAME)) byte_cnt_q <= byte_cnt_q + 1'b1;

      if (sfd_hit)                          err_rx_q <= 1'b0;
      else if (nib_en && mii_rxer)          err_rx_q <= 1'b1;

      if (sfd_hit)         dribble_q <= 1'b0;
      else if (frame_end)  dribble_q <= half;

      if (sfd_hit)   first_pend_q <= 1'b1;
      else if (emit) first_pend_q <= 1'b0;

      drain_cnt_q <= (state_q == S_DRAIN) ? ~drain_cnt_q : 1'b0;
    end
  end

  // registered output stage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid       <= 1'b0;
      out_data        <= 8'h00;
      out_sof         <= 1'b0;
      out_eof         <= 1'b0;
      out_err         <= 1'b0;
      illegal_carrier <= 1'b0;
    end else begin
      out_valid       <= rx_en && emit;
      out_data        <= emit ? hold_out : 8'h00;
      out_sof         <= rx_en && emit && first_pend_q;
      out_eof         <= rx_en && (state_q == S_ENDR);
      out_err         <= rx_en && (state_q == S_ENDR) && (err_rx_q || dribble_q || runt || !crc_ok);
      illegal_carrier <= rx_en && illegal_ev;
    end
  end

  // R1
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (state_q == S_HALT) && !out_valid && !out_eof && !illegal_carrier);

  // R6
  eof_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> !out_valid);

  // R6
  err_with_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> out_eof);

  // R5
  sof_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid);

  // R3
  illegal_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_carrier |=> !illegal_carrier);

  // R4
  drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DISC) |-> !out_valid && !out_eof);

  // R5
  emit_after_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb && (state_q == S_DEST)) |-> !emit);

endmodule

// File: tb/mii_rx_parser_tb_top.sv
module mii_rx_parser_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_en = 1'b0;
  logic        promisc = 1'b0;
  logic [47:0] own_addr = 48'hA5_34_12_CD_7E_02;
  logic [3:0]  mii_rxd = 4'h0;
  logic        mii_rxdv = 1'b0;
  logic        mii_rxer = 1'b0;
  logic        out_valid, out_sof, out_eof, out_err, illegal_carrier;
  logic [7:0]  out_data;

  always #10 clk = ~clk;

  mii_rx_parser dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .promisc(promisc), .own_addr(own_addr),
    .mii_rxd(mii_rxd), .mii_rxdv(mii_rxdv), .mii_rxer(mii_rxer),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
    .out_eof(out_eof), .out_err(out_err), .illegal_carrier(illegal_carrier)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  // frame and nibble buffers
  logic [7:0] fr [0:255];
  int         flen;
  logic [3:0] nb [0:700];
  logic       ner [0:700];
  int         nlen;

  // monitor
  logic [7:0] got [0:255];
  int got_len, sofs, sof_bad, eofs, ill;
  bit got_err;

  always @(negedge clk) begin
    if (out_valid) begin
      if (got_len < 256) got[got_len] = out_data;
      if (out_sof) begin sofs++; if (got_len != 0) sof_bad++; end
      got_len++;
    end
    if (out_eof) begin eofs++; got_err = out_err; end
    if (illegal_carrier) ill++;
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 8; b++) begin
        logic fb = c[0] ^ fr[i][b];
        c = {1'b0, c[31:1]};
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    return c;
  endfunction

  function automatic bit fcs_good();
    logic [31:0] rx_fcs;
    if (flen < 4) return 0;
    rx_fcs = {fr[flen-1], fr[flen-2], fr[flen-3], fr[flen-4]};
    return (~ref_crc(flen - 4)) == rx_fcs;
  endfunction

  function automatic bit exp_accept();
    bit own_m = 1, bc = 1;
    if (flen < 6) return 0;
    for (int i = 0; i < 6; i++) begin
      if (fr[i] != own_addr[8*i +: 8]) own_m = 0;
      if (fr[i] != 8'hFF) bc = 0;
    end
    return promisc || own_m || bc || fr[0][0];
  endfunction

  // kind: 0 own, 1 broadcast, 2 multicast, 3 other unicast
  task automatic mk_frame(input int len, input int kind, input bit corrupt);
    logic [31:0] f;
    flen = len;
    for (int i = 0; i < len - 4; i++) fr[i] = 8'($urandom);
    for (int i = 0; i < 6; i++) begin
      case (kind)
        0: fr[i] = own_addr[8*i +: 8];
        1: fr[i] = 8'hFF;
        default: ;
      endcase
    end
    if (kind == 2) fr[0][0] = 1'b1;
    if (kind == 3) begin fr[0][0] = 1'b0; fr[1] = own_addr[15:8] ^ 8'h40; end
    f = ~ref_crc(len - 4);
    for (int i = 0; i < 4; i++) fr[len-4+i] = f[8*i +: 8];
    if (corrupt) fr[len-1] = fr[len-1] ^ 8'h10;
  endtask

  // build nibble stream: npre preamble nibbles, SFD, bytes low nibble first
  task automatic mk_nibs(input int npre, input int er_byte, input bit extra);
    nlen = 0;
    for (int i = 0; i < npre; i++) begin nb[nlen] = 4'h5; ner[nlen] = 0; nlen++; end
    nb[nlen] = 4'hD; ner[nlen] = 0; nlen++;
    for (int i = 0; i < flen; i++) begin
      nb[nlen] = fr[i][3:0]; ner[nlen] = (i == er_byte); nlen++;
      nb[nlen] = fr[i][7:4]; ner[nlen] = 0; nlen++;
    end
    if (extra) begin nb[nlen] = 4'h3; ner[nlen] = 0; nlen++; end
  endtask

  task automatic play();
    got_len = 0; sofs = 0; sof_bad = 0; eofs = 0; ill = 0; got_err = 0;
    for (int i = 0; i < nlen; i++) begin
      @(negedge clk); mii_rxdv = 1'b1; mii_rxd = nb[i]; mii_rxer = ner[i];
    end
    @(negedge clk); mii_rxdv = 1'b0; mii_rxd = 4'h0; mii_rxer = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic chk_frame(input string req, input bit er, input bit extra);
    bit acc = exp_accept();
    bit eerr = er || !fcs_good() || (flen < 64) || extra;
    int elen = acc ? flen - 4 : 0;
    int mism = 0;
    check(got_len == elen, req, "byte count", got_len, elen);
    for (int i = 0; i < elen && i < got_len; i++) if (got[i] != fr[i]) mism++;
    check(mism == 0, "R5", "byte mismatches", mism, 0);
    check(sofs == (elen > 0 ? 1 : 0) && sof_bad == 0, "R5", "sof count", sofs, (elen > 0 ? 1 : 0));
    check(eofs == (acc ? 1 : 0), "R6", "eof count", eofs, (acc ? 1 : 0));
    if (acc) check(got_err == eerr, req, "error flag", got_err, eerr);
    check(ill == 0, "R3", "illegal pulses on good start", ill, 0);
  endtask

  task automatic chk_illegal(input string what);
    check(ill == 1, "R3", what, ill, 1);
    check(got_len == 0 && eofs == 0, "R3", {what, " output"}, got_len + eofs, 0);
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!out_valid && !out_sof && !out_eof && !out_err && !illegal_carrier && out_data == 0,
          "R1", "outputs after reset", out_valid, 0);

    // R1 halted: a good frame has no effect
    mk_frame(70, 0, 0); mk_nibs(15, -1, 0); play();
    check(got_len == 0 && eofs == 0 && ill == 0, "R1", "activity while halted", got_len + eofs + ill, 0);

    rx_en = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R4 R5 R6 R7 directed good frame, own address, minimum preamble
    mk_frame(64, 0, 0); mk_nibs(4, -1, 0); play(); chk_frame("R2", 0, 0);
    // R4 broadcast and multicast
    mk_frame(80, 1, 0); mk_nibs(15, -1, 0); play(); chk_frame("R4", 0, 0);
    mk_frame(66, 2, 0); mk_nibs(15, -1, 0); play(); chk_frame("R4", 0, 0);
    // R4 other station dropped, then accepted in promiscuous mode
    mk_frame(70, 3, 0); mk_nibs(15, -1, 0); play(); chk_frame("R4", 0, 0);
    promisc = 1'b1;
    mk_nibs(15, -1, 0); play(); chk_frame("R4", 0, 0);
    promisc = 1'b0;
    // R7 bad check bytes
    mk_frame(72, 0, 1); mk_nibs(15, -1, 0); play(); chk_frame("R7", 0, 0);
    // R8 error strobe mid payload
    mk_frame(72, 1, 0); mk_nibs(15, 30, 0); play(); chk_frame("R8", 1, 0);
    // R9 runt with good CRC
    mk_frame(40, 0, 0); mk_nibs(15, -1, 0); play(); chk_frame("R9", 0, 0);
    // R10 odd trailing nibble
    mk_frame(68, 0, 0); mk_nibs(15, -1, 1); play(); chk_frame("R10", 0, 1);
    // R11 frame cut inside the address
    flen = 4; for (int i = 0; i < 4; i++) fr[i] = 8'hFF;
    mk_nibs(15, -1, 0); play();
    check(got_len == 0 && eofs == 0 && ill == 0, "R11", "truncated address", got_len + eofs + ill, 0);

    // R3 malformed starts
    nlen = 3; nb[0] = 4'hA; nb[1] = 4'h5; nb[2] = 4'hD;
    for (int i = 0; i < 3; i++) ner[i] = 0;
    play(); chk_illegal("bad first nibble");
    nlen = 3; nb[0] = 4'h5; nb[1] = 4'h5; nb[2] = 4'hD;
    play(); chk_illegal("early delimiter");
    nlen = 6; for (int i = 0; i < 6; i++) begin nb[i] = 4'h5; ner[i] = (i == 4); end
    play(); chk_illegal("error in preamble");
    nlen = 5; for (int i = 0; i < 5; i++) begin nb[i] = 4'h5; ner[i] = 0; end
    play(); chk_illegal("carrier without delimiter");
    nlen = 7; for (int i = 0; i < 7; i++) begin nb[i] = (i == 5) ? 4'h7 : 4'h5; ner[i] = 0; end
    play(); chk_illegal("bad nibble in preamble");

    // R4 R5 R7 R8 R9 R10 random frames
    for (int k = 0; k < 24; k++) begin
      int len = 50 + int'($urandom % 50);
      int kind = int'($urandom % 4);
      bit corrupt = ($urandom % 5) == 0;
      int erb = (($urandom % 6) == 0) ? 8 + int'($urandom % 30) : -1;
      bit extra = ($urandom % 8) == 0;
      promisc = ($urandom % 4) == 0;
      mk_frame(len, kind, corrupt);
      mk_nibs(6 + int'($urandom % 10), erb, extra);
      play();
      chk_frame("R5", erb >= 0, extra);
    end
    promisc = 1'b0;

    // R1 disable again: carrier ignored
    rx_en = 1'b0;
    mk_frame(70, 1, 0); mk_nibs(15, -1, 0); play();
    check(got_len == 0 && eofs == 0 && ill == 0, "R1", "activity after disable", got_len + eofs + ill, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule